// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block turns frames arriving on one serial line into a parallel word with status flags. The line rests high. A frame opens with a low start bit, carries 7 or 8 data bits, may carry one extra bit, and closes with one or two high stop bits. The data bits can arrive least-significant first or most-significant first. In normal mode the extra bit is an even or odd parity bit. In multiprocessor mode it is an address/data marker that is handed to the host unchecked.

A 16x oversampling tick from an external rate generator paces the receiver. The line passes through a synchronizer. A falling edge is taken as a start bit only if the line is still low at the middle of that bit. Each later bit is sampled once, at its middle.

The received word is posted at the first stop bit. A second stop bit, when selected, is still checked and still counts as line activity, so the bus idle indication waits for it to finish. A read strobe empties the holding register and clears its flags.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, rx_full, par_err, frm_err and ovr_err are 0, rx_data is 0x00, rx_addr_bit is 0 and bus_idle is 1.
- R2: A low pulse on rxd that has ended before the middle of the start bit (8 ticks after detection) produces no frame, leaves rx_full at 0 and leaves bus_idle unchanged.
- R3: One bit lasts 16 ticks. A frame is a low start bit, then d data bits (d = 8 when cfg_len8 = 1, otherwise 7), then one extra bit when cfg_par_en or cfg_mp_mode is 1, then 1 stop bit (2 when cfg_two_stop = 1). With cfg_msb_first = 0 the first data bit received is placed in rx_data[0].
- R4: With cfg_msb_first = 1 the first data bit received is placed in rx_data[d-1] and the last in rx_data[0].
- R5: With cfg_len8 = 0, rx_data[7] reads 0 for every frame.
- R6: With cfg_par_en = 1 and cfg_mp_mode = 0, the bit after the data is parity. Under cfg_par_odd = 0 the count of ones in the data bits plus the parity bit must be even; under cfg_par_odd = 1 it must be odd. A mismatch sets par_err with the posted word.
- R7: With cfg_mp_mode = 1, the bit after the data appears on rx_addr_bit and par_err stays 0 whatever cfg_par_en is. In normal mode rx_addr_bit is 0.
- R8: rx_full rises at the middle of the first stop bit, and is already 1 during the second stop bit when two stop bits are selected.
- R9: frm_err is set when the first stop bit samples low. It is also set when the second stop bit of an accepted frame samples low.
- R10: bus_idle falls when a start bit is accepted. It rises half a bit after the middle of the last stop bit if no new start has been seen, so with two stop bits it stays 0 throughout the second stop bit.
- R11: A frame that completes while rx_full is 1 and no read is strobed sets ovr_err and is dropped; rx_data and the other flags keep the earlier word.
- R12: A one-cycle rd_strobe clears rx_full, ovr_err, par_err and frm_err. If a frame completes in the same cycle, the new word is posted, rx_full stays 1 and ovr_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_msb_first | input | 1 | 1: most-significant data bit first |
| cfg_par_en | input | 1 | Parity bit present (normal mode) |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_mp_mode | input | 1 | Multiprocessor mode, extra bit is address/data marker |
| cfg_two_stop | input | 1 | Two stop bits |
| rd_strobe | input | 1 | Read of the holding register, one cycle |
| rx_data | output | 8 | Received word |
| rx_addr_bit | output | 1 | Address/data marker of the posted word |
| rx_full | output | 1 | Holding register full |
| par_err | output | 1 | Parity mismatch on posted word |
| frm_err | output | 1 | Low stop bit on posted word |
| ovr_err | output | 1 | A frame was dropped while full |
| bus_idle | output | 1 | Line idle after the last stop bit |

## Verification
A read strobe and a frame completion can land on the same clock edge. This decides whether a word is posted or counted as an overrun. The bench first times a frame from its start edge to the rise of rx_full while the tick phase is held fixed. It then fills the register and replays a frame with the same phase, placing the read strobe on exactly that edge. The result is judged at the ports: rx_full must stay 1, ovr_err must stay 0 and rx_data must hold the new word. A lost read shows up as an overrun, and a read that wins shows up as an empty register.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_XTRA, S_STOP1, S_STOP2, S_HOLD
  } rx_state_t;

  // index of the final data bit for the chosen length
  function automatic logic [IDX_W-1:0] last_idx(input logic len8);
    return len8 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
  endfunction

  // register position of the n-th received data bit
  function automatic logic [IDX_W-1:0] data_pos(input logic [IDX_W-1:0] n,
                                                input logic len8,
                                                input logic msb);
    return msb ? (last_idx(len8) - n) : n;
  endfunction

  // parity check: data ones plus parity bit must be even (odd when odd=1)
  function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                      input logic pbit,
                                      input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/sfr_line_sync.sv
module sfr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q[0] <= 1'b1;
          else        q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q[i] <= 1'b1;
          else        q[i] <= q[i-1];
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/sfr_bit_engine.sv
module sfr_bit_engine
  import sfr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              cfg_len8,
  input  logic              cfg_msb,
  input  logic              cfg_xtra,
  input  logic              cfg_two_stop,
  output logic              ev_start_ok,
  output logic              ev_glitch,
  output logic              ev_stop1,
  output logic              ev_stop2,
  output logic              ev_idle_set,
  output logic [DATA_W-1:0] dbuf,
  output logic              xbit,
  output logic              busy
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OVS - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_last;
  logic             samp;

  assign cnt_last = (state == S_START || state == S_HOLD) ? MID : FULL;
  assign samp     = tick && (state != S_IDLE) && (cnt == cnt_last);

  assign ev_start_ok = samp && (state == S_START) && !rxd;
  assign ev_glitch   = samp && (state == S_START) &&  rxd;
  assign ev_stop1    = samp && (state == S_STOP1);
  assign ev_stop2    = samp && (state == S_STOP2);
  assign ev_idle_set = samp && (state == S_HOLD) && rxd;
  assign busy        = (state == S_DATA) || (state == S_XTRA) ||
                       (state == S_STOP1) || (state == S_STOP2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      dbuf  <= '0;
      xbit  <= 1'b0;
    end else if (tick) begin
      if ((state == S_IDLE || state == S_HOLD) && !rxd) begin
        state <= S_START;
        cnt   <= '0;
      end else if (state == S_IDLE) begin
        cnt <= '0;
      end else if (cnt != cnt_last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (state)
          S_START: begin
            if (!rxd) begin
              state <= S_DATA;
              idx   <= '0;
              dbuf  <= '0;
            end else begin
              state <= S_HOLD;
            end
          end
          S_DATA: begin
            dbuf[data_pos(idx, cfg_len8, cfg_msb)] <= rxd;
            if (idx == last_idx(cfg_len8))
              state <= cfg_xtra ? S_XTRA : S_STOP1;
            else
              idx <= idx + 1'b1;
          end
          S_XTRA: begin
            xbit  <= rxd;
            state <= S_STOP1;
          end
          S_STOP1: state <= cfg_two_stop ? S_STOP2 : S_HOLD;
          S_STOP2: state <= S_HOLD;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfr_holding.sv
module sfr_holding
  import sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_stop1,
  input  logic              ev_stop2,
  input  logic              line_bit,
  input  logic [DATA_W-1:0] dbuf,
  input  logic              xbit,
  input  logic              cfg_mp_mode,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rd_strobe,
  output logic              ev_load,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr_bit,
  output logic              rx_full,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err
);
  logic accepted;
  logic par_chk;

  assign ev_load = ev_stop1 && (!rx_full || rd_strobe);
  assign par_chk = cfg_par_en && !cfg_mp_mode && parity_bad(dbuf, xbit, cfg_par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_addr_bit <= 1'b0;
      rx_full     <= 1'b0;
      par_err     <= 1'b0;
      frm_err     <= 1'b0;
      ovr_err     <= 1'b0;
      accepted    <= 1'b0;
    end else if (ev_load) begin
      rx_data     <= dbuf;
      rx_addr_bit <= cfg_mp_mode ? xbit : 1'b0;
      rx_full     <= 1'b1;
      par_err     <= par_chk;
      frm_err     <= !line_bit;
      ovr_err     <= 1'b0;
      accepted    <= 1'b1;
    end else begin
      if (rd_strobe) begin
        rx_full  <= 1'b0;
        par_err  <= 1'b0;
        frm_err  <= 1'b0;
        ovr_err  <= 1'b0;
        accepted <= 1'b0;
      end
      if (ev_stop1) begin
        ovr_err  <= 1'b1;
        accepted <= 1'b0;
      end
      if (ev_stop2 && !line_bit && accepted && !rd_strobe)
        frm_err <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              cfg_len8,
  input  logic              cfg_msb_first,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_mp_mode,
  input  logic              cfg_two_stop,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr_bit,
  output logic              rx_full,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              bus_idle
);
  logic              rxd_s;
  logic              ev_start_ok, ev_glitch, ev_stop1, ev_stop2, ev_idle_set;
  logic              ev_load;
  logic              engine_busy;
  logic [DATA_W-1:0] dbuf;
  logic              xbit;

  sfr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  sfr_bit_engine #(.OVS(OVS)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s),
    .cfg_len8(cfg_len8), .cfg_msb(cfg_msb_first),
    .cfg_xtra(cfg_par_en || cfg_mp_mode), .cfg_two_stop(cfg_two_stop),
    .ev_start_ok(ev_start_ok), .ev_glitch(ev_glitch),
    .ev_stop1(ev_stop1), .ev_stop2(ev_stop2), .ev_idle_set(ev_idle_set),
    .dbuf(dbuf), .xbit(xbit), .busy(engine_busy)
  );

  sfr_holding u_hold (
    .clk(clk), .rst_n(rst_n), .ev_stop1(ev_stop1), .ev_stop2(ev_stop2),
    .line_bit(rxd_s), .dbuf(dbuf), .xbit(xbit),
    .cfg_mp_mode(cfg_mp_mode), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rd_strobe(rd_strobe), .ev_load(ev_load),
    .rx_data(rx_data), .rx_addr_bit(rx_addr_bit), .rx_full(rx_full),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bus_idle <= 1'b1;
    else if (ev_start_ok) bus_idle <= 1'b0;
    else if (ev_idle_set) bus_idle <= 1'b1;
  end
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       cfg_len8,
  input logic       cfg_mp_mode,
  input logic       ev_stop1,
  input logic       ev_load,
  input logic       ev_start_ok,
  input logic       ev_glitch,
  input logic       engine_busy,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       par_err,
  input logic       ovr_err,
  input logic       bus_idle
);
  p_glitch_keeps_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_glitch |=> $stable(bus_idle));

  p_bit7_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load && !cfg_len8 |=> !rx_data[7]);

  p_mp_no_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load && cfg_mp_mode |=> !par_err);

  p_full_at_stop1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop1 && !rx_full |=> rx_full);

  p_start_clears_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_ok |=> !bus_idle);

  p_idle_low_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |-> !bus_idle);

  p_overrun_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop1 && rx_full && !rd_strobe |=> ovr_err && $stable(rx_data));

  p_read_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !ev_stop1 |=> !rx_full && !ovr_err);

  p_collide_posts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop1 && rd_strobe |=> rx_full && !ovr_err);
endmodule

bind serial_frame_rx sfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
  .cfg_len8(cfg_len8), .cfg_mp_mode(cfg_mp_mode),
  .ev_stop1(ev_stop1), .ev_load(ev_load), .ev_start_ok(ev_start_ok),
  .ev_glitch(ev_glitch), .engine_busy(engine_busy),
  .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err),
  .ovr_err(ovr_err), .bus_idle(bus_idle)
);

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
  localparam int BIT_CLK = 64; // 16 ticks of 4 clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic cfg_len8 = 1'b1, cfg_msb_first = 1'b0, cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0, cfg_mp_mode = 1'b0, cfg_two_stop = 1'b0;
  logic rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic rx_addr_bit, rx_full, par_err, frm_err, ovr_err, bus_idle;

  int n_chk = 0;
  int n_bad = 0;
  int tph = 0;
  logic snap_full1, snap_idle1, snap_full2, snap_idle2;

  always #4 clk = ~clk;

  serial_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .cfg_len8(cfg_len8), .cfg_msb_first(cfg_msb_first), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_mode(cfg_mp_mode), .cfg_two_stop(cfg_two_stop),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_addr_bit(rx_addr_bit),
    .rx_full(rx_full), .par_err(par_err), .frm_err(frm_err),
    .ovr_err(ovr_err), .bus_idle(bus_idle)
  );

  initial begin
    forever begin
      @(negedge clk);
      tph  = (tph + 1) % 4;
      tick = (tph == 0);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic pbit(input logic [7:0] d, input logic len8, input logic odd);
    logic [7:0] m;
    m = len8 ? d : (d & 8'h7f);
    return (^m) ^ odd;
  endfunction

  task automatic set_cfg(input logic len8, input logic msb, input logic pen,
                         input logic podd, input logic mp, input logic two);
    cfg_len8 = len8; cfg_msb_first = msb; cfg_par_en = pen;
    cfg_par_odd = podd; cfg_mp_mode = mp; cfg_two_stop = two;
  endtask

  task automatic align();
    @(posedge clk);
    while (tph != 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rxd = 1'b1;
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  // start, data (order per cfg), optional extra bit, stop bit(s); assumes aligned
  task automatic send_frame(input logic [7:0] d, input logic xval,
                            input logic s1, input logic s2);
    int nb;
    nb = cfg_len8 ? 8 : 7;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++)
      drive_bit(cfg_msb_first ? d[nb-1-i] : d[i]);
    if (cfg_par_en || cfg_mp_mode) drive_bit(xval);
    rxd = s1;
    repeat (48) @(negedge clk);
    snap_full1 = rx_full; snap_idle1 = bus_idle;
    repeat (16) @(negedge clk);
    if (cfg_two_stop) begin
      rxd = s2;
      repeat (48) @(negedge clk);
      snap_full2 = rx_full; snap_idle2 = bus_idle;
      repeat (16) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic frame(input logic [7:0] d, input logic xval, input logic s1, input logic s2);
    align();
    send_frame(d, xval, s1, s2);
    idle_bits(3);
  endtask

  task automatic rd_pulse();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "rx_full", rx_full, 0);
    chk("R1", "rx_data", rx_data, 0);
    chk("R1", "errors", {par_err, frm_err, ovr_err, rx_addr_bit}, 0);
    chk("R1", "bus_idle", bus_idle, 1);
  endtask

  task automatic t_lsb8();
    set_cfg(1, 0, 0, 0, 0, 0);
    frame(8'hA5, 0, 1, 1);
    chk("R3", "lsb8 data", rx_data, 8'hA5);
    chk("R8", "full after frame", rx_full, 1);
    chk("R10", "idle after stop", bus_idle, 1);
    chk("R10", "idle during stop", snap_idle1, 0);
    chk("R9", "no frm", frm_err, 0);
    rd_pulse();
    chk("R12", "read clears full", rx_full, 0);
  endtask

  task automatic t_msb();
    set_cfg(1, 1, 0, 0, 0, 0);
    frame(8'h3C, 0, 1, 1);
    chk("R4", "msb8 data", rx_data, 8'h3C);
    rd_pulse();
    set_cfg(0, 1, 0, 0, 0, 0);
    frame(8'h35, 0, 1, 1);
    chk("R4", "msb7 data", rx_data, 8'h35);
    rd_pulse();
  endtask

  task automatic t_seven();
    set_cfg(0, 0, 0, 0, 0, 0);
    frame(8'hDA, 0, 1, 1);
    chk("R5", "7-bit data bit7 zero", rx_data, 8'h5A);
    rd_pulse();
  endtask

  task automatic t_parity();
    set_cfg(1, 0, 1, 0, 0, 0);
    frame(8'h07, pbit(8'h07, 1, 0), 1, 1);
    chk("R6", "even ok", par_err, 0);
    chk("R6", "even data", rx_data, 8'h07);
    rd_pulse();
    frame(8'h07, ~pbit(8'h07, 1, 0), 1, 1);
    chk("R6", "even bad", par_err, 1);
    rd_pulse();
    chk("R12", "read clears par", par_err, 0);
    set_cfg(0, 1, 1, 1, 0, 0);
    frame(8'h2B, pbit(8'h2B, 0, 1), 1, 1);
    chk("R6", "odd ok 7-bit msb", par_err, 0);
    chk("R6", "odd data", rx_data, 8'h2B);
    rd_pulse();
  endtask

  task automatic t_multiproc();
    set_cfg(1, 0, 1, 0, 1, 0);
    frame(8'h42, 1, 1, 1); // extra bit would be a parity mismatch
    chk("R7", "addr bit", rx_addr_bit, 1);
    chk("R7", "no parity check", par_err, 0);
    chk("R7", "data", rx_data, 8'h42);
    rd_pulse();
    frame(8'h42, 0, 1, 1);
    chk("R7", "data bit", rx_addr_bit, 0);
    rd_pulse();
  endtask

  task automatic t_two_stop();
    set_cfg(1, 0, 0, 0, 0, 1);
    frame(8'h96, 0, 1, 1);
    chk("R8", "full during stop2", snap_full2, 1);
    chk("R8", "full in stop1", snap_full1, 1);
    chk("R10", "idle low in stop2", snap_idle2, 0);
    chk("R10", "idle after stop2", bus_idle, 1);
    chk("R9", "no frm", frm_err, 0);
    rd_pulse();
    frame(8'h96, 0, 1, 0);
    chk("R9", "stop2 low frm", frm_err, 1);
    chk("R9", "stop2 low data kept", rx_data, 8'h96);
    rd_pulse();
  endtask

  task automatic t_framing();
    set_cfg(1, 0, 0, 0, 0, 0);
    frame(8'h81, 0, 0, 1);
    chk("R9", "stop1 low frm", frm_err, 1);
    chk("R9", "full", rx_full, 1);
    rd_pulse();
    chk("R12", "read clears frm", frm_err, 0);
  endtask

  task automatic t_glitch();
    align();
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2", "idle kept mid", bus_idle, 1);
    idle_bits(2);
    chk("R2", "no frame", rx_full, 0);
    chk("R2", "idle kept", bus_idle, 1);
  endtask

  task automatic t_overrun();
    set_cfg(1, 0, 0, 0, 0, 0);
    frame(8'h11, 0, 1, 1);
    frame(8'h22, 0, 1, 1);
    chk("R11", "ovr set", ovr_err, 1);
    chk("R11", "old data kept", rx_data, 8'h11);
    rd_pulse();
    chk("R12", "ovr cleared", ovr_err, 0);
    chk("R12", "full cleared", rx_full, 0);
  endtask

  task automatic t_collide();
    int cnt;
    set_cfg(1, 0, 0, 0, 0, 0);
    cnt = 0;
    align();
    fork
      send_frame(8'h0F, 0, 1, 1);
      begin
        while (!rx_full) begin @(negedge clk); cnt++; end
      end
    join
    idle_bits(3);
    rd_pulse();
    frame(8'h5A, 0, 1, 1);
    align();
    fork
      send_frame(8'hC3, 0, 1, 1);
      begin
        repeat (cnt - 1) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
      end
    join
    idle_bits(3);
    chk("R12", "collide full", rx_full, 1);
    chk("R12", "collide no ovr", ovr_err, 0);
    chk("R12", "collide new data", rx_data, 8'hC3);
    rd_pulse();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_lsb8();
    t_msb();
    t_seven();
    t_parity();
    t_multiproc();
    t_two_stop();
    t_framing();
    t_glitch();
    t_overrun();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule